// File: doc/BRIEF.md
# Incremental Encoder Position Tracker

This block turns the two phase lines and the index line of an incremental shaft encoder into a position count. Each of the three lines is first brought into the clock domain. It then passes through a glitch filter whose sample rate is set by a divider input. The two phase lines are decoded either at double resolution (edges of phase A only) or at quadruple resolution (every edge of both phases). The block keeps a position register that counts up or down between zero and a programmable ceiling. It also reports the direction of the last count, and a rising index edge returns the position to zero.

A fallback mode ignores the encoder and runs the same register as a free-running timer that advances once per clock. In every counting mode, wrapping past the ceiling raises a one-cycle rollover pulse and wrapping below zero raises a one-cycle underflow pulse. A hold mode freezes the register. Software access is left to the surrounding logic.

Top module: `qenc_tracker`

## Requirements
- R1: While `rst_n` is low and after its release, `pos_o` is 0, `dir_o` is 0 and both `ovf_o` and `unf_o` are 0 until the first count event.
- R2: With `mode_i` = 2'b11 (x4), every change of exactly one phase line counts one step. The step is up when the new level of A differs from the previous level of B, so the sequence (A,B) 00,10,11,01,00 counts four up, and the reverse sequence counts down.
- R3: With `mode_i` = 2'b10 (x2), only changes of A count, using the same direction rule (up when the new A differs from B). Changes of B alone leave the position unchanged.
- R4: `dir_o` is 1 after an up step and 0 after a down step, and it keeps its value when no step occurs.
- R5: A filtered line takes a new level only after three consecutive filter samples agree on it. A filter sample is taken once every `flt_div_i`+1 clocks, so a level held for fewer than three samples is ignored.
- R6: In x2 or x4 mode, a rising edge of the filtered index line sets `pos_o` to 0, and this takes precedence over a step in the same cycle.
- R7: An up step from a position equal to `max_cnt_i` gives position 0 and a one-cycle pulse on `ovf_o`.
- R8: A down step from position 0 gives position `max_cnt_i` and a one-cycle pulse on `unf_o`.
- R9: With `mode_i` = 2'b01 (timer), the position advances by one on every clock, wraps as in R7, sets `dir_o` to 1, and ignores the phase and index lines.
- R10: With `mode_i` = 2'b00 (hold), the position and direction do not change, whatever the encoder lines do.
- R11: When both phase lines change in the same filtered cycle, no step is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ph_a_i | input | 1 | Encoder phase A, asynchronous |
| ph_b_i | input | 1 | Encoder phase B, asynchronous |
| idx_i | input | 1 | Encoder index pulse, asynchronous |
| mode_i | input | 2 | 00 hold, 01 timer, 10 x2 decode, 11 x4 decode |
| flt_div_i | input | 8 | Filter sample period minus one, in clocks |
| max_cnt_i | input | 16 | Ceiling of the position range |
| pos_o | output | 16 | Position count |
| dir_o | output | 1 | Direction of the last step, 1 = up |
| ovf_o | output | 1 | One-cycle pulse on wrap from the ceiling to zero |
| unf_o | output | 1 | One-cycle pulse on wrap from zero to the ceiling |

## Verification
The quadrature sequence is run forward and backward in x4 mode. This separates correct edge counting from direction errors, and the backward run also crosses zero so that the underflow wrap is covered. The same sequence in x2 mode shows whether edges of B are wrongly counted. A simultaneous change of both phases checks that the illegal transition is rejected. A short glitch, and a level held for just under and then well over three slow filter samples, locate the acceptance threshold of the filter. Index pulses, a small ceiling that forces a rollover, a hold-mode run and a timer run with toggling index then isolate the clearing, wrap, freeze and fallback behaviours.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_TIMER = 2'b01,
    MODE_X2    = 2'b10,
    MODE_X4    = 2'b11
  } qenc_mode_e;

  localparam int unsigned FILT_TAPS = 3;
endpackage

// File: rtl/qenc_tick_gen.sv
module qenc_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= div_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the sample period restarts after every tick
  p_tick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int unsigned TAPS = qenc_pkg::FILT_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int unsigned HW = TAPS - 1;

  logic [1:0]    sync_q;
  logic [HW-1:0] hist_q, hist_d;
  logic          dout_q, dout_d;
  logic          all_hi, all_lo;

  always_comb begin
    all_hi = tick_i & (&{hist_q, sync_q[1]});
    all_lo = tick_i & ~(|{hist_q, sync_q[1]});
    dout_d = all_hi ? 1'b1 : (all_lo ? 1'b0 : dout_q);
    hist_d = hist_q;
    if (tick_i) begin
      if (HW > 1) hist_d = {hist_q[HW-2:0], sync_q[1]};
      else        hist_d = sync_q[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      dout_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din_i};
      hist_q <= hist_d;
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  // R5: the filtered level moves only on a sample tick
  p_move_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_q) |-> $past(tick_i));
  // R5: a rise requires the synchronised input to be high when sampled
  p_rise_needs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_q) |-> $past(sync_q[1]));
endmodule

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  qenc_mode_e mode_i,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       x_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       idx_rise_o
);
  logic a_q, b_q, x_q;
  logic a_chg, b_chg, fwd, step;

  always_comb begin
    a_chg = a_i ^ a_q;
    b_chg = b_i ^ b_q;
    fwd   = a_i ^ b_q;
    unique case (mode_i)
      MODE_X4: step = a_chg ^ b_chg;
      MODE_X2: step = a_chg & ~b_chg;
      default: step = 1'b0;
    endcase
    up_o       = step & fwd;
    dn_o       = step & ~fwd;
    idx_rise_o = x_i & ~x_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      x_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      x_q <= x_i;
    end
  end

  // R4: a step is never up and down at once
  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_o, dn_o}));
  // R11: a change on both phases yields no step
  p_both_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg) |-> !(up_o || dn_o));
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qenc_mode_e       mode_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             idx_i,
  input  logic [POS_W-1:0] max_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             dir_q, dir_d, ovf_q, ovf_d, unf_q, unf_d;
  logic             quad, go_up, go_dn;

  always_comb begin
    quad  = (mode_i == MODE_X2) || (mode_i == MODE_X4);
    go_up = (mode_i == MODE_TIMER) || (quad && up_i);
    go_dn = quad && dn_i;
    pos_d = pos_q;
    dir_d = dir_q;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (quad && idx_i) begin
      pos_d = '0;
    end else if (go_up) begin
      dir_d = 1'b1;
      if (pos_q >= max_i) begin
        pos_d = '0;
        ovf_d = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end else if (go_dn) begin
      dir_d = 1'b0;
      if (pos_q == '0) begin
        pos_d = max_i;
        unf_d = 1'b1;
      end else begin
        pos_d = pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      dir_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      dir_q <= dir_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign pos_o = pos_q;
  assign dir_o = dir_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_ovf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (pos_q == '0));
  p_unf_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> (pos_q == $past(max_i)));
  p_idx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(quad && idx_i) |-> (pos_q == '0));
  p_timer_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == MODE_TIMER && $past(pos_q) < $past(max_i))
      |-> (pos_q == $past(pos_q) + 1'b1));
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == MODE_HOLD) |-> ($stable(pos_q) && $stable(dir_q)));
endmodule

// File: rtl/qenc_tracker.sv
module qenc_tracker
  import qenc_pkg::*;
#(
  parameter int unsigned POS_W = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_a_i,
  input  logic             ph_b_i,
  input  logic             idx_i,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] flt_div_i,
  input  logic [POS_W-1:0] max_cnt_i,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam int unsigned NLINES = 3;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              tick;
  logic [NLINES-1:0] raw, filt;
  logic              up, dn, idx_rise;
  qenc_mode_e        mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign mode = qenc_mode_e'(mode_i);
  assign raw  = {idx_i, ph_b_i, ph_a_i};

  qenc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .div_i(flt_div_i), .tick_o(tick)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    qenc_glitch_filter #(.TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n_s), .tick_i(tick),
      .din_i(raw[i]), .dout_o(filt[i])
    );
  end

  qenc_edge_decode u_dec (
    .clk(clk), .rst_n(rst_n_s), .mode_i(mode),
    .a_i(filt[0]), .b_i(filt[1]), .x_i(filt[2]),
    .up_o(up), .dn_o(dn), .idx_rise_o(idx_rise)
  );

  qenc_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .mode_i(mode),
    .up_i(up), .dn_i(dn), .idx_i(idx_rise), .max_i(max_cnt_i),
    .pos_o(pos_o), .dir_o(dir_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // R1: outputs stay at rest while the internal reset is active
  p_reset_rest_r1: assert property (@(posedge clk)
    !rst_n_s |=> (!rst_n_s || (pos_o == '0 && !ovf_o && !unf_o)));
endmodule

// File: tb/qenc_tracker_test.sv
module qenc_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_a = 1'b0, ph_b = 1'b0, idx = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  div = 8'd0;
  logic [15:0] maxc = 16'd100;
  logic [15:0] pos_o;
  logic        dir_o, ovf_o, unf_o;

  typedef struct {
    logic [15:0] pos;
    logic        dir;
    int          ovf;
    int          unf;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, n_ovf = 0, n_unf = 0;
  int m_pos = 0, m_ovf = 0, m_unf = 0;
  logic m_dir = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  qenc_tracker uut (
    .clk(clk), .rst_n(rst_n), .ph_a_i(ph_a), .ph_b_i(ph_b), .idx_i(idx),
    .mode_i(mode), .flt_div_i(div), .max_cnt_i(maxc),
    .pos_o(pos_o), .dir_o(dir_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always @(negedge clk) begin
    if (rst_n && ovf_o) n_ovf++;
    if (rst_n && unf_o) n_unf++;
  end

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pos_o !== e.pos || dir_o !== e.dir || n_ovf != e.ovf || n_unf != e.unf) begin
          errors++;
          $display("FAIL %s: pos=%0d dir=%0b ovf=%0d unf=%0d expected pos=%0d dir=%0b ovf=%0d unf=%0d",
                   e.req, pos_o, dir_o, n_ovf, n_unf, e.pos, e.dir, e.ovf, e.unf);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    wait_clk(4 * (int'(div) + 1) + 8);
  endtask

  task automatic push(input string req);
    exp_t e;
    e.pos = m_pos[15:0]; e.dir = m_dir; e.ovf = m_ovf; e.unf = m_unf; e.req = req;
    q.push_back(e);
    wait_clk(2);
  endtask

  task automatic model_up();
    m_dir = 1'b1;
    if (m_pos >= int'(maxc)) begin m_pos = 0; m_ovf++; end
    else m_pos++;
  endtask

  task automatic model_dn();
    m_dir = 1'b0;
    if (m_pos == 0) begin m_pos = int'(maxc); m_unf++; end
    else m_pos--;
  endtask

  // driver: move phases, update model from the requirements, push
  task automatic move(input logic na, input logic nb, input string req);
    logic ca, cb, fwd, cnt;
    ca = na ^ ph_a; cb = nb ^ ph_b; fwd = na ^ ph_b;
    cnt = (mode == 2'b11) ? (ca ^ cb) : (mode == 2'b10) ? (ca & ~cb) : 1'b0;
    if (cnt) begin
      if (fwd) model_up(); else model_dn();
    end
    ph_a = na; ph_b = nb;
    settle();
    push(req);
  endtask

  task automatic index_pulse(input string req);
    idx = 1'b1; settle();
    if (mode[1]) m_pos = 0;
    idx = 1'b0; settle();
    push(req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_clk(3);
    // R1: reset state while reset held
    push("R1 in reset");
    rst_n = 1'b1;
    wait_clk(4);
    push("R1 after release");

    mode = 2'b11;
    // R2 / R4: forward x4 sequence
    move(1, 0, "R2 fwd 10"); move(1, 1, "R2 fwd 11");
    move(0, 1, "R2 fwd 01"); move(0, 0, "R2 fwd 00 R4 up");
    // R2 / R8: reverse x4 across zero
    move(0, 1, "R2 rev"); move(1, 1, "R2 rev"); move(1, 0, "R2 rev");
    move(0, 0, "R4 down at zero"); move(0, 1, "R8 underflow"); move(1, 1, "R8 after wrap");
    // R6: index clears in x4
    index_pulse("R6 index x4");
    // R11: both phases change together
    move(0, 0, "R11 both change");

    // R3: x2 counts A edges only
    mode = 2'b10;
    move(1, 0, "R3 A rise"); move(1, 1, "R3 B only");
    move(0, 1, "R3 A fall"); move(0, 0, "R3 B only");
    move(0, 1, "R3 B only rev"); move(1, 1, "R3 A rise down");
    move(1, 0, "R3 B only rev"); move(0, 0, "R3 A fall down");
    move(1, 0, "R3 up before index");
    index_pulse("R6 index x2");

    // R7: rollover with small ceiling
    mode = 2'b11; maxc = 16'd3;
    move(1, 1, "R7 step1"); move(0, 1, "R7 step2");
    move(0, 0, "R7 step3"); move(1, 0, "R7 rollover");

    // R5: short glitch at fastest sampling is ignored
    ph_a = 1'b0; wait_clk(2); ph_a = 1'b1;
    settle();
    push("R5 glitch ignored");
    // R5: slow sampling, level held short of three samples
    div = 8'd3;
    settle();
    ph_b = 1'b1;
    wait_clk(8);
    exp_t_push_hold();
    settle();
    model_up();
    push("R5 accepted after three samples");
    div = 8'd0;
    settle();

    // R10: hold mode freezes position and direction
    mode = 2'b00;
    move(0, 1, "R10 hold"); move(0, 0, "R10 hold"); move(0, 1, "R10 hold");

    // R9: timer mode, phases and index ignored
    maxc = 16'd9;
    mode = 2'b01;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (i == 4) idx = 1'b1;
      if (i == 8) ph_a = ~ph_a;
      if (i == 16) idx = 1'b0;
      model_up();
    end
    mode = 2'b00;
    settle();
    push("R9 timer count and wrap");

    wait_clk(4);
    while (q.size() > 0) wait_clk(1);
    wait_clk(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic exp_t_push_hold();
    push("R5 not yet accepted");
  endtask
endmodule